// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide programming interface of an eight-line programmable interrupt controller. A host writes bytes to one of two addresses, selected by `a0_i`, and reads bytes back from them. The decoder handles two kinds of write. The first kind is the start-up sequence of initialization words, which sets the vector base and the nesting and end-of-interrupt modes. The second kind is the run-time commands: end-of-interrupt variants, priority rotation and read-register selection. It holds the interrupt mask and the mode bits, and it holds the rotation offset that the priority resolver uses to decide which line currently ranks highest.

The in-service register lives beside the resolver. The decoder receives it as an input and returns one-cycle clear strobes for it. The request register is also an input, used only for read-back. Every write takes effect at the clock edge on which `wr_i` is sampled high. Registered outputs and clear strobes therefore show the result one cycle after the write. Read data is combinational while `rd_i` is high. Poll requests, single-controller operation and level-mode selection in the first initialization word are accepted and have no effect.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset, the mask, vector base, rotation offset, all mode flags and the clear strobes are zero. The initialization step is "run", so a write to address 1 loads the mask. `dout_o` is zero whenever `rd_i` is low.
- R2: A write to address 0 with data bit 4 set starts initialization. On the next cycle the mask, rotation offset, read select (set back to request), special-mask flag, nested-mode flag, auto-EOI flag and rotate-on-auto-EOI flag are all zero. `isr_clr_o` is all ones for exactly that one cycle.
- R3: After the start word, the next address-1 write loads the vector base from data bits 7:3; the low three bits of `vec_base_o` read zero. The following address-1 write is the cascade word and has no visible effect. If bit 0 of the start word was set, one more address-1 write is the mode word. The step then returns to run. No address-1 write inside the sequence changes the mask.
- R4: In the mode word, data bit 4 sets `sfnm_o` and data bit 1 sets `aeoi_o`.
- R5: In the run step, an address-1 write copies the data byte into `mask_o`.
- R6: An address-0 write with bit 4 clear and bit 3 set is a read-control command. Data bit 0 sets the read select (1 = in-service, 0 = request). Data bit 5 sets `smask_o`.
- R7: Any other address-0 write is an operation command with code = data bits 7:5. Codes 0 and 4 set `rot_aeoi_o` to data bit 7 and raise no clear strobe.
- R8: Codes 1 and 5 strobe the clear bit of the highest-priority set bit of `isr_i`. Priority order starts at line `rot_off_o` and rises modulo 8. Code 5 also loads the rotation offset with (that line + 1) mod 8. If `isr_i` is zero, neither code has any effect.
- R9: Codes 3 and 7 strobe the clear bit of line data[2:0], whether or not that bit is in service. Code 7 also loads the rotation offset with (line + 1) mod 8. Code 3 leaves it unchanged.
- R10: Code 6 loads the rotation offset with (data[2:0] + 1) mod 8 and raises no strobe. Code 2 changes nothing.
- R11: While `rd_i` is high, `dout_o` shows the mask when `a0_i` is 1. When `a0_i` is 0 it shows `isr_i` if the read select is 1 and `irr_i` otherwise.
- R12: Read-control and operation commands on address 0 act in every initialization step and do not advance the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a0_i | input | 1 | Register address select |
| wr_i | input | 1 | Write strobe, one byte per sampled cycle |
| rd_i | input | 1 | Read strobe, gates `dout_o` |
| din_i | input | 8 | Write data |
| irr_i | input | 8 | Request register from the resolver, for read-back |
| isr_i | input | 8 | In-service register from the resolver |
| dout_o | output | 8 | Read data |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| rot_off_o | output | 3 | Rotation offset; this line has highest priority |
| sfnm_o | output | 1 | Special fully nested mode |
| aeoi_o | output | 1 | Automatic end-of-interrupt |
| rot_aeoi_o | output | 1 | Rotate on automatic end-of-interrupt |
| smask_o | output | 1 | Special mask mode |
| isr_clr_o | output | 8 | One-cycle in-service clear strobes |

## Verification
Every state register of the decoder is either a port or visible through read-back. The read select shows up in which source `dout_o` carries, and the initialization step shows up in where the next address-1 byte lands. A corrupted register is therefore visible within one cycle of the next write that depends on it. A wrong rotation offset is the subtle case: it only shows when a non-specific end-of-interrupt meets an in-service pattern with more than one bit set. For that reason the priority search is swept over every offset and every in-service pattern.

// File: rtl/picd_pkg.sv
package picd_pkg;

    parameter int unsigned DW = 8;
    localparam int unsigned LW = $clog2(DW);
    localparam int unsigned OPW = 3;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BASE = 2'd1,
        ST_CASC = 2'd2,
        ST_MODE = 2'd3
    } step_t;

    typedef enum logic [OPW-1:0] {
        OP_RAE_CLR = 3'd0,
        OP_NS_EOI  = 3'd1,
        OP_NOP     = 3'd2,
        OP_SP_EOI  = 3'd3,
        OP_RAE_SET = 3'd4,
        OP_RNS_EOI = 3'd5,
        OP_SET_PRI = 3'd6,
        OP_RSP_EOI = 3'd7
    } opc_t;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_INIT,
        WK_RDCTL,
        WK_OPCMD,
        WK_BASE,
        WK_CASC,
        WK_MODE,
        WK_MASK
    } wkind_t;

    typedef struct packed {
        logic          hit;
        logic [LW-1:0] line;
    } pick_t;

    // Highest-priority set bit of vec; line 'off' ranks first, rising modulo DW.
    function automatic pick_t top_pick(logic [DW-1:0] vec, logic [LW-1:0] off);
        pick_t r;
        r = '0;
        for (int k = DW - 1; k >= 0; k--) begin
            logic [LW-1:0] ln;
            ln = off + LW'(k);
            if (vec[ln]) begin
                r.hit  = 1'b1;
                r.line = ln;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/picd_wclass.sv
module picd_wclass
    import picd_pkg::*;
(
    input  logic   wr_i,
    input  logic   a0_i,
    input  logic   b4_i,
    input  logic   b3_i,
    input  step_t  step_i,
    output wkind_t kind_o
);
    always_comb begin
        kind_o = WK_NONE;
        if (wr_i) begin
            if (!a0_i) begin
                if (b4_i)      kind_o = WK_INIT;
                else if (b3_i) kind_o = WK_RDCTL;
                else           kind_o = WK_OPCMD;
            end else begin
                unique case (step_i)
                    ST_RUN:  kind_o = WK_MASK;
                    ST_BASE: kind_o = WK_BASE;
                    ST_CASC: kind_o = WK_CASC;
                    ST_MODE: kind_o = WK_MODE;
                    default: kind_o = WK_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/picd_seq.sv
module picd_seq
    import picd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  wkind_t kind_i,
    input  logic   need4_i,
    output step_t  step_o
);
    step_t step_q;
    logic  need4_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= ST_RUN;
            need4_q <= 1'b0;
        end else begin
            unique case (kind_i)
                WK_INIT: begin
                    step_q  <= ST_BASE;
                    need4_q <= need4_i;
                end
                WK_BASE: step_q <= ST_CASC;
                WK_CASC: step_q <= need4_q ? ST_MODE : ST_RUN;
                WK_MODE: step_q <= ST_RUN;
                default: step_q <= step_q;
            endcase
        end
    end

    assign step_o = step_q;

    // R12: commands and idle cycles never move the sequence
    a_r12_step_hold: assert property (@(posedge clk) disable iff (rst)
        (kind_i == WK_NONE || kind_i == WK_RDCTL || kind_i == WK_OPCMD) |=> $stable(step_q));

    // R3: a start word always leads to the base step
    a_r3_init_to_base: assert property (@(posedge clk) disable iff (rst)
        (kind_i == WK_INIT) |=> (step_q == ST_BASE));

endmodule

// File: rtl/picd_eoi.sv
module picd_eoi
    import picd_pkg::*;
(
    input  logic          en_i,
    input  opc_t          op_i,
    input  logic [LW-1:0] sel_i,
    input  logic [DW-1:0] isr_i,
    input  logic [LW-1:0] rot_i,
    output logic [DW-1:0] clr_o,
    output logic          rot_we_o,
    output logic [LW-1:0] rot_nx_o
);
    pick_t pk;

    always_comb begin
        pk       = top_pick(isr_i, rot_i);
        clr_o    = '0;
        rot_we_o = 1'b0;
        rot_nx_o = rot_i;
        if (en_i) begin
            unique case (op_i)
                OP_NS_EOI, OP_RNS_EOI: begin
                    if (pk.hit) begin
                        clr_o[pk.line] = 1'b1;
                        if (op_i == OP_RNS_EOI) begin
                            rot_we_o = 1'b1;
                            rot_nx_o = pk.line + 1'b1;
                        end
                    end
                end
                OP_SP_EOI, OP_RSP_EOI: begin
                    clr_o[sel_i] = 1'b1;
                    if (op_i == OP_RSP_EOI) begin
                        rot_we_o = 1'b1;
                        rot_nx_o = sel_i + 1'b1;
                    end
                end
                OP_SET_PRI: begin
                    rot_we_o = 1'b1;
                    rot_nx_o = sel_i + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
    import picd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          a0_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [7:0]    din_i,
    input  logic [7:0]    irr_i,
    input  logic [7:0]    isr_i,
    output logic [7:0]    dout_o,
    output logic [7:0]    mask_o,
    output logic [7:0]    vec_base_o,
    output logic [2:0]    rot_off_o,
    output logic          sfnm_o,
    output logic          aeoi_o,
    output logic          rot_aeoi_o,
    output logic          smask_o,
    output logic [7:0]    isr_clr_o
);
    localparam int unsigned BASE_LSB = LW;

    wkind_t        kind;
    step_t         step;
    opc_t          op;
    logic [DW-1:0] eoi_clr;
    logic          rot_we;
    logic [LW-1:0] rot_nx;
    logic          rd_sel_q;

    assign op = opc_t'(din_i[DW-1 -: OPW]);

    picd_wclass u_wclass (
        .wr_i   (wr_i),
        .a0_i   (a0_i),
        .b4_i   (din_i[4]),
        .b3_i   (din_i[3]),
        .step_i (step),
        .kind_o (kind)
    );

    picd_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .kind_i  (kind),
        .need4_i (din_i[0]),
        .step_o  (step)
    );

    picd_eoi u_eoi (
        .en_i     (kind == WK_OPCMD),
        .op_i     (op),
        .sel_i    (din_i[LW-1:0]),
        .isr_i    (isr_i),
        .rot_i    (rot_off_o),
        .clr_o    (eoi_clr),
        .rot_we_o (rot_we),
        .rot_nx_o (rot_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o     <= '0;
            vec_base_o <= '0;
            rot_off_o  <= '0;
            sfnm_o     <= 1'b0;
            aeoi_o     <= 1'b0;
            rot_aeoi_o <= 1'b0;
            smask_o    <= 1'b0;
            rd_sel_q   <= 1'b0;
            isr_clr_o  <= '0;
        end else begin
            isr_clr_o <= '0;
            unique case (kind)
                WK_INIT: begin
                    mask_o     <= '0;
                    rot_off_o  <= '0;
                    sfnm_o     <= 1'b0;
                    aeoi_o     <= 1'b0;
                    rot_aeoi_o <= 1'b0;
                    smask_o    <= 1'b0;
                    rd_sel_q   <= 1'b0;
                    isr_clr_o  <= '1;
                end
                WK_RDCTL: begin
                    rd_sel_q <= din_i[0];
                    smask_o  <= din_i[5];
                end
                WK_OPCMD: begin
                    if (op == OP_RAE_CLR || op == OP_RAE_SET)
                        rot_aeoi_o <= din_i[DW-1];
                    isr_clr_o <= eoi_clr;
                    if (rot_we)
                        rot_off_o <= rot_nx;
                end
                WK_BASE: vec_base_o <= {din_i[DW-1:BASE_LSB], {BASE_LSB{1'b0}}};
                WK_MODE: begin
                    sfnm_o <= din_i[4];
                    aeoi_o <= din_i[1];
                end
                WK_MASK: mask_o <= din_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        dout_o = '0;
        if (rd_i)
            dout_o = a0_i ? mask_o : (rd_sel_q ? isr_i : irr_i);
    end

    // R2: the start word clears state and flushes the in-service register
    a_r2_init_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !a0_i && din_i[4]) |=> (mask_o == '0 && rot_off_o == '0 && isr_clr_o == '1
            && !sfnm_o && !aeoi_o && !rot_aeoi_o && !smask_o));

    // R5: a run-step address-1 write lands in the mask
    a_r5_mask_load: assert property (@(posedge clk) disable iff (rst)
        (wr_i && a0_i && step == ST_RUN) |=> (mask_o == $past(din_i)));

    // R3: address-1 writes inside the sequence leave the mask alone
    a_r3_mask_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_i && a0_i && step != ST_RUN) |=> $stable(mask_o));

    // R9: specific EOI strobes exactly the named line
    a_r9_spec_eoi: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !a0_i && din_i[4:3] == 2'b00 && din_i[6:5] == 2'b11)
            |=> (isr_clr_o == (8'b1 << $past(din_i[2:0]))));

    // R8: a non-specific EOI only clears a bit that was in service
    a_r8_ns_in_service: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !a0_i && din_i[4:3] == 2'b00 && din_i[6:5] == 2'b01)
            |=> ($onehot0(isr_clr_o) && (isr_clr_o & ~$past(isr_i)) == '0));

    // R10: no write, no rotation change
    a_r10_rot_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(rot_off_o));

endmodule

// File: tb/test_pic_cmd_decoder.sv
`timescale 1ns/1ps
module test_pic_cmd_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a0 = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0] din = '0, irr = '0, isr = '0;
    logic [7:0] dout, mask, vbase, clr;
    logic [2:0] rot;
    logic       sfnm, aeoi, rae, smask;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pic_cmd_decoder i_pic_cmd_decoder (
        .clk(clk), .rst(rst), .a0_i(a0), .wr_i(wr), .rd_i(rd), .din_i(din),
        .irr_i(irr), .isr_i(isr), .dout_o(dout), .mask_o(mask), .vec_base_o(vbase),
        .rot_off_o(rot), .sfnm_o(sfnm), .aeoi_o(aeoi), .rot_aeoi_o(rae),
        .smask_o(smask), .isr_clr_o(clr)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // drive a write at a negedge; returns at the next negedge, after the capturing edge
    task automatic wbyte(input logic addr, input logic [7:0] d);
        @(negedge clk);
        a0 = addr; din = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rbyte(input logic addr, output logic [7:0] d);
        a0 = addr; rd = 1'b1;
        #1 d = dout;
        rd = 1'b0;
    endtask

    function automatic logic [7:0] ns_pick(input logic [7:0] v, input int off);
        for (int k = 0; k < 8; k++)
            if (v[(off + k) % 8]) return 8'(1 << ((off + k) % 8));
        return 8'h00;
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 mask", mask, 8'h00);
        chk("R1 base", vbase, 8'h00);
        chk("R1 rot", {5'b0, rot}, 8'h00);
        chk("R1 flags", {4'b0, sfnm, aeoi, rae, smask}, 8'h00);
        chk("R1 clr", clr, 8'h00);
        chk("R1 dout idle", dout, 8'h00);
        wbyte(1'b1, 8'h3C);
        chk("R1 run step mask", mask, 8'h3C);

        // dirty state, then R2 start word
        wbyte(1'b0, 8'hC5);            // set priority, rot=6
        wbyte(1'b0, 8'h29);            // R6 read select isr, smask
        chk("R6 smask set", {7'b0, smask}, 8'h01);
        wbyte(1'b0, 8'h80);            // R7 rotate on aeoi set
        chk("R7 rae set", {7'b0, rae}, 8'h01);
        chk("R7 no strobe", clr, 8'h00);
        wbyte(1'b0, 8'h11);
        chk("R2 mask", mask, 8'h00);
        chk("R2 rot", {5'b0, rot}, 8'h00);
        chk("R2 flags", {4'b0, sfnm, aeoi, rae, smask}, 8'h00);
        chk("R2 clr all", clr, 8'hFF);
        irr = 8'h96; isr = 8'h41;
        rbyte(1'b0, rv);
        chk("R2 rdsel back to irr", rv, 8'h96);
        @(negedge clk);
        chk("R2 clr one cycle", clr, 8'h00);

        // R12 command inside the sequence, then R3/R4
        wbyte(1'b0, 8'h09);
        rbyte(1'b0, rv);
        chk("R12 rdctl in base step", rv, 8'h41);
        wbyte(1'b1, 8'hA5);
        chk("R3 base", vbase, 8'hA0);
        chk("R3 mask kept base", mask, 8'h00);
        wbyte(1'b1, 8'h04);
        chk("R3 mask kept casc", mask, 8'h00);
        wbyte(1'b1, 8'h12);
        chk("R4 mode", {6'b0, sfnm, aeoi}, 8'h03);
        chk("R3 mask kept mode", mask, 8'h00);
        wbyte(1'b1, 8'h5A);
        chk("R3 back to run", mask, 8'h5A);

        // R3 without mode word; R4 single bits
        wbyte(1'b0, 8'h10);
        wbyte(1'b1, 8'h08);
        chk("R3 base 2", vbase, 8'h08);
        wbyte(1'b1, 8'h00);
        wbyte(1'b1, 8'h10);
        chk("R3 no mode word", mask, 8'h10);
        chk("R4 untouched", {6'b0, sfnm, aeoi}, 8'h00);
        wbyte(1'b0, 8'h11); wbyte(1'b1, 8'hF8); wbyte(1'b1, 8'h00); wbyte(1'b1, 8'h02);
        chk("R4 aeoi only", {6'b0, sfnm, aeoi}, 8'h01);
        chk("R3 base 3", vbase, 8'hF8);

        // R5/R11 full mask sweep
        for (int v = 0; v < 256; v++) begin
            wbyte(1'b1, 8'(v));
            chk("R5 mask", mask, 8'(v));
            rbyte(1'b1, rv);
            chk("R11 mask read", rv, 8'(v));
        end

        // R6/R11 read select sweep
        wbyte(1'b0, 8'h08);
        chk("R6 smask clear", {7'b0, smask}, 8'h00);
        for (int v = 0; v < 256; v += 17) begin
            irr = 8'(v); isr = ~8'(v);
            rbyte(1'b0, rv);
            chk("R11 irr read", rv, 8'(v));
        end
        wbyte(1'b0, 8'h09);
        for (int v = 0; v < 256; v += 17) begin
            irr = 8'(v); isr = ~8'(v);
            rbyte(1'b0, rv);
            chk("R11 isr read", rv, ~8'(v));
        end

        // R7 clear
        wbyte(1'b0, 8'h00);
        chk("R7 rae clear", {7'b0, rae}, 8'h00);

        // R10 set priority and nop
        for (int l = 0; l < 8; l++) begin
            wbyte(1'b0, 8'hC0 | 8'(l));
            chk("R10 rot", {5'b0, rot}, 8'((l + 1) % 8));
            chk("R10 no strobe", clr, 8'h00);
        end
        isr = 8'hFF;
        wbyte(1'b0, 8'h43);
        chk("R10 nop rot", {5'b0, rot}, 8'h00);
        chk("R10 nop clr", clr, 8'h00);

        // R8 exhaustive over offset and in-service pattern
        for (int off = 0; off < 8; off++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] e;
                e = ns_pick(8'(v), off);
                isr = 8'(v);
                wbyte(1'b0, 8'hC0 | 8'((off + 7) % 8));
                wbyte(1'b0, 8'h20);
                chk("R8 ns clr", clr, e);
                chk("R8 ns rot kept", {5'b0, rot}, 8'(off));
                wbyte(1'b0, 8'hA0);
                chk("R8 rns clr", clr, e);
                if (e == 8'h00)
                    chk("R8 rns empty", {5'b0, rot}, 8'(off));
                else
                    chk("R8 rns rot", {5'b0, rot}, 8'(($clog2(int'(e)) + 1) % 8));
            end
        end

        // R9 specific EOI, with and without rotation
        isr = 8'h00;
        for (int l = 0; l < 8; l++) begin
            wbyte(1'b0, 8'hC2);
            wbyte(1'b0, 8'h60 | 8'(l));
            chk("R9 sp clr", clr, 8'(1 << l));
            chk("R9 sp rot kept", {5'b0, rot}, 8'h03);
            wbyte(1'b0, 8'hE0 | 8'(l));
            chk("R9 rsp clr", clr, 8'(1 << l));
            chk("R9 rsp rot", {5'b0, rot}, 8'((l + 1) % 8));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule